// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block decides which of four operating conditions a processor core package is in: normal running, a light halt, a deep halt, or a stop-grant condition requested by the platform. From that condition it drives one clock enable per internal clock section. Each low-power condition turns off a different set of sections. A clock-gating cell placed next to each section uses the enable.

A halt request from the core leads to the deep halt only when software has enabled it and the core is not already at its lowest bus-to-core ratio. Otherwise the request leads to the light halt. An active-low stop-clock pin overrides everything else. When the pin returns high, the block goes back to whatever condition it held before. On every entry into stop-grant, the block sends a burst of acknowledge strobes, one for each core, on consecutive cycles, each tagged with the core index. A wake input ends either halt. On a wake, the block first passes through a short waking step in which every clock is already on, and only then reports running.

Top module: `lps_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the state code is 0 (running), all four clock enables are 1 and the acknowledge strobe is 0.
- R2: In running with stop-clock high, a halt request with deep-halt enabled and the minimum-ratio flag clear moves the state to code 2 (deep halt) after one clock edge. Only enable bit 3 stays set (mask 4'b1000).
- R3: In running with stop-clock high, a halt request with deep-halt enable clear moves the state to code 1 (light halt) after one clock edge. Only enable bit 0 (core execution) is cleared (mask 4'b1110).
- R4: When the minimum-ratio flag is set, a halt request moves the state to code 1, whatever the deep-halt enable holds.
- R5: A low stop-clock pin in any state other than stop-grant moves the state to code 4 (stop-grant) after one clock edge, even if a halt request is present at the same time. Enable mask in stop-grant: 4'b1100 (core and cache clocks off).
- R6: While the pin is low, the block stays in stop-grant. When the pin returns high, the state after the next edge is the state held just before stop-grant was entered.
- R7: A wake in code 1 or code 2 moves the state to code 3 (waking), with all enables 1, after one edge. The state reaches code 0 one edge later.
- R8: Each entry into stop-grant produces strobes for cores 0, 1, …, NUM_CORES-1 on consecutive cycles. The strobe for core 0 comes in the first cycle that reports code 4. A new entry restarts the burst at core 0.
- R9: Enable bit 3 (bus snoop and interrupt logic) is never cleared.
- R10: Wake has no effect in running or stop-grant. A halt request has no effect outside running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Halt request from the core |
| ehalt_en | input | 1 | Software enable for the deep halt |
| at_min_ratio | input | 1 | Core already at its lowest bus-to-core ratio |
| stpclk_n | input | 1 | Active-low stop-clock pin |
| wake | input | 1 | Wake or interrupt event |
| state | output | 3 | Current state code (0 run, 1 halt, 2 deep halt, 3 waking, 4 stop-grant) |
| clk_en | output | 4 | Section clock enables: bit0 core, bit1 cache, bit2 bus/uncore, bit3 snoop+interrupt |
| sgack_strobe | output | 1 | Stop-grant acknowledge strobe |
| sgack_core | output | CORE_W | Core index carried by the strobe |

## Verification
Every output comes from a registered state, so an input applied before a rising edge shows up in the cycle that follows that edge. For a wake, the all-on enables appear one edge after the wake and the running code appears two edges after it. The strobe for core i appears i cycles after the first stop-grant cycle. The bench changes inputs on falling edges and advances a behavioural model on rising edges. It compares state, enables, strobe and core index at every falling edge, so each result is sampled exactly in the cycle it is due.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int NUM_DOMAINS = 4;
  localparam int DOM_CORE    = 0;
  localparam int DOM_CACHE   = 1;
  localparam int DOM_BUS     = 2;
  localparam int DOM_SNOOP   = 3;

  typedef enum logic [2:0] {
    PS_RUN   = 3'd0,
    PS_HALT  = 3'd1,
    PS_EHALT = 3'd2,
    PS_WAKE  = 3'd3,
    PS_SGNT  = 3'd4
  } pstate_t;

  // Clock sections left running in each state.
  function automatic logic [NUM_DOMAINS-1:0] dom_mask(pstate_t s);
    logic [NUM_DOMAINS-1:0] m;
    m = '1;
    case (s)
      PS_HALT:  m[DOM_CORE] = 1'b0;
      PS_SGNT:  begin m[DOM_CORE] = 1'b0; m[DOM_CACHE] = 1'b0; end
      PS_EHALT: begin m = '0; m[DOM_SNOOP] = 1'b1; end
      default:  m = '1;
    endcase
    return m;
  endfunction

  // Which halt flavour a halt request selects.
  function automatic pstate_t halt_target(logic en, logic at_min);
    return (en && !at_min) ? PS_EHALT : PS_HALT;
  endfunction
endpackage

// File: rtl/lps_fsm.sv
module lps_fsm
  import lps_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    halt_req,
  input  logic    ehalt_en,
  input  logic    at_min_ratio,
  input  logic    stop_req,
  input  logic    wake,
  output pstate_t state,
  output logic    sg_enter,
  output logic    wake_exit
);
  pstate_t st, st_nxt, saved, saved_nxt;

  assign sg_enter  = stop_req && (st != PS_SGNT);
  assign wake_exit = !stop_req && wake && ((st == PS_HALT) || (st == PS_EHALT));

  always_comb begin
    st_nxt    = st;
    saved_nxt = saved;
    if (sg_enter) begin
      st_nxt    = PS_SGNT;
      saved_nxt = st;
    end else begin
      case (st)
        PS_RUN:   if (halt_req) st_nxt = halt_target(ehalt_en, at_min_ratio);
        PS_HALT,
        PS_EHALT: if (wake_exit) st_nxt = PS_WAKE;
        PS_WAKE:  st_nxt = PS_RUN;
        PS_SGNT:  if (!stop_req) st_nxt = saved;
        default:  st_nxt = PS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= PS_RUN;
      saved <= PS_RUN;
    end else begin
      st    <= st_nxt;
      saved <= saved_nxt;
    end
  end

  assign state = st;
endmodule

// File: rtl/lps_clk_gate.sv
module lps_clk_gate
  import lps_pkg::*;
(
  input  pstate_t                state,
  output logic [NUM_DOMAINS-1:0] clk_en
);
  logic [NUM_DOMAINS-1:0] mask;
  assign mask = dom_mask(state);

  for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_dom
    if (g == DOM_SNOOP) begin : g_always_on
      assign clk_en[g] = 1'b1;
    end else begin : g_gated
      assign clk_en[g] = mask[g];
    end
  end
endmodule

// File: rtl/lps_sgack_seq.sv
module lps_sgack_seq #(
  parameter int NUM_CORES = 4,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              strobe,
  output logic [CORE_W-1:0] core
);
  localparam logic [CORE_W-1:0] LAST_IDX = CORE_W'(NUM_CORES - 1);

  logic              active;
  logic [CORE_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active) begin
      if (idx == LAST_IDX) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + CORE_W'(1);
      end
    end
  end

  assign strobe = active;
  assign core   = idx;
endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_req,
  input  logic              ehalt_en,
  input  logic              at_min_ratio,
  input  logic              stpclk_n,
  input  logic              wake,
  output logic [2:0]        state,
  output logic [3:0]        clk_en,
  output logic              sgack_strobe,
  output logic [CORE_W-1:0] sgack_core
);
  pstate_t st;
  logic    stop_req;
  logic    sg_enter;
  logic    wake_exit;

  assign stop_req = ~stpclk_n;

  lps_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_req     (halt_req),
    .ehalt_en     (ehalt_en),
    .at_min_ratio (at_min_ratio),
    .stop_req     (stop_req),
    .wake         (wake),
    .state        (st),
    .sg_enter     (sg_enter),
    .wake_exit    (wake_exit)
  );

  lps_clk_gate u_gate (
    .state  (st),
    .clk_en (clk_en)
  );

  lps_sgack_seq #(.NUM_CORES(NUM_CORES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (sg_enter),
    .strobe (sgack_strobe),
    .core   (sgack_core)
  );

  assign state = st;
endmodule

// File: rtl/lps_ctrl_chk.sv
module lps_ctrl_chk
  import lps_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt_req,
  input logic              ehalt_en,
  input logic              at_min_ratio,
  input logic              stpclk_n,
  input logic              wake,
  input logic [2:0]        state,
  input logic [3:0]        clk_en,
  input logic              sgack_strobe,
  input logic [CORE_W-1:0] sgack_core,
  input logic              sg_enter,
  input logic              wake_exit
);
  localparam logic [CORE_W-1:0] LAST_IDX = CORE_W'(NUM_CORES - 1);

  a_r2_deep_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && stpclk_n && halt_req && ehalt_en && !at_min_ratio)
      |=> (state == 3'd2 && clk_en == 4'b1000));

  a_r3_light_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && stpclk_n && halt_req && !ehalt_en)
      |=> (state == 3'd1 && clk_en == 4'b1110));

  a_r4_min_ratio_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && stpclk_n && halt_req && at_min_ratio) |=> (state == 3'd1));

  a_r5_stop_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (!stpclk_n && state != 3'd4) |=> (state == 3'd4 && clk_en == 4'b1100));

  a_r6_hold_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && !stpclk_n) |=> (state == 3'd4));

  a_r7_wake_step: assert property (@(posedge clk) disable iff (!rst_n)
    wake_exit |=> (state == 3'd3 && clk_en == 4'b1111));

  a_r7_wake_to_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd3 && stpclk_n) |=> (state == 3'd0));

  a_r8_first_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sg_enter |=> (sgack_strobe && sgack_core == '0));

  a_r8_next_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (sgack_strobe && sgack_core != LAST_IDX && !sg_enter)
      |=> (sgack_strobe && sgack_core == $past(sgack_core) + CORE_W'(1)));

  a_r8_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
    (sgack_strobe && sgack_core == LAST_IDX && !sg_enter) |=> !sgack_strobe);

  a_r9_snoop_on: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en[DOM_SNOOP]);

  a_r10_wake_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && stpclk_n && !halt_req && wake) |=> (state == 3'd0));
endmodule

bind lps_ctrl lps_ctrl_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .halt_req     (halt_req),
  .ehalt_en     (ehalt_en),
  .at_min_ratio (at_min_ratio),
  .stpclk_n     (stpclk_n),
  .wake         (wake),
  .state        (state),
  .clk_en       (clk_en),
  .sgack_strobe (sgack_strobe),
  .sgack_core   (sgack_core),
  .sg_enter     (sg_enter),
  .wake_exit    (wake_exit)
);

// File: tb/lps_ctrl_tb.sv
`timescale 1ns/1ps
module lps_ctrl_tb;
  localparam int NCORES = 4;
  localparam int CW     = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 1'b0, ehalt_en = 1'b0, at_min_ratio = 1'b0;
  logic stpclk_n = 1'b1, wake = 1'b0;
  logic [2:0]    state;
  logic [3:0]    clk_en;
  logic          sgack_strobe;
  logic [CW-1:0] sgack_core;

  always #10 clk = ~clk;

  lps_ctrl #(.NUM_CORES(NCORES)) u_dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .ehalt_en(ehalt_en),
    .at_min_ratio(at_min_ratio), .stpclk_n(stpclk_n), .wake(wake),
    .state(state), .clk_en(clk_en), .sgack_strobe(sgack_strobe),
    .sgack_core(sgack_core)
  );

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // Behavioural reference: 0 run, 1 halt, 2 deep, 3 waking, 4 stop-grant
  int m_st = 0;
  int m_prev = 0;
  int m_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st <= 0; m_prev <= 0; m_q = {};
    end else begin
      if (!stpclk_n && m_st != 4) begin
        m_prev <= m_st;
        m_st   <= 4;
        m_q = {};
        for (int i = 0; i < NCORES; i++) m_q.push_back(i);
      end else begin
        if (m_q.size() > 0) void'(m_q.pop_front());
        if (m_st == 0 && halt_req)                         m_st <= (ehalt_en && !at_min_ratio) ? 2 : 1;
        else if ((m_st == 1 || m_st == 2) && wake)         m_st <= 3;
        else if (m_st == 3)                                m_st <= 0;
        else if (m_st == 4 && stpclk_n)                    m_st <= m_prev;
      end
    end
  end

  function automatic logic [3:0] exp_en(int s);
    logic [3:0] e;
    e[3] = 1'b1;
    e[2] = (s != 2);
    e[1] = !(s == 2 || s == 4);
    e[0] = (s == 0 || s == 3);
    return e;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare on every falling edge; R9 is covered by the bit-3 enable compare.
  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, "state", int'(state), m_st);
      check(cur_req, "clk_en", int'(clk_en), int'(exp_en(m_st)));
      check("R9", "snoop enable", int'(clk_en[3]), 1);
      check(cur_req, "strobe", int'(sgack_strobe), (m_q.size() > 0) ? 1 : 0);
      if (m_q.size() > 0) check(cur_req, "core index", int'(sgack_core), m_q[0]);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cur_req = "R1";                       // reset values
    step(3);
    rst_n = 1'b1;
    step(2);

    cur_req = "R2";                       // deep halt
    ehalt_en = 1'b1; halt_req = 1'b1; step(1); halt_req = 1'b0; step(2);
    cur_req = "R10";                      // halt request outside run ignored
    halt_req = 1'b1; step(2); halt_req = 1'b0;
    cur_req = "R7";                       // wake out of deep halt
    wake = 1'b1; step(1); wake = 1'b0; step(3);

    cur_req = "R3";                       // light halt
    ehalt_en = 1'b0; halt_req = 1'b1; step(1); halt_req = 1'b0; step(2);
    cur_req = "R7";
    wake = 1'b1; step(1); wake = 1'b0; step(3);

    cur_req = "R4";                       // minimum-ratio fallback
    ehalt_en = 1'b1; at_min_ratio = 1'b1; halt_req = 1'b1; step(1);
    halt_req = 1'b0; at_min_ratio = 1'b0; step(2);
    wake = 1'b1; step(1); wake = 1'b0; step(3);

    cur_req = "R10";                      // wake in run ignored
    wake = 1'b1; step(3); wake = 1'b0; step(1);

    cur_req = "R5";                       // stop beats a halt request
    stpclk_n = 1'b0; halt_req = 1'b1; step(1); halt_req = 1'b0;
    cur_req = "R8"; step(5);
    cur_req = "R10"; wake = 1'b1; step(2); wake = 1'b0;
    cur_req = "R6"; stpclk_n = 1'b1; step(3);

    cur_req = "R6";                       // return to deep halt
    halt_req = 1'b1; step(1); halt_req = 1'b0; step(1);
    stpclk_n = 1'b0; step(6); stpclk_n = 1'b1; step(3);
    wake = 1'b1; step(1); wake = 1'b0; step(3);

    cur_req = "R8";                       // re-entry restarts burst
    stpclk_n = 1'b0; step(1); stpclk_n = 1'b1; step(1);
    stpclk_n = 1'b0; step(7); stpclk_n = 1'b1; step(3);

    cur_req = "R5";                       // stop during waking step
    ehalt_en = 1'b0; halt_req = 1'b1; step(1); halt_req = 1'b0; step(1);
    wake = 1'b1; step(1); wake = 1'b0; stpclk_n = 1'b0; step(6);
    cur_req = "R6"; stpclk_n = 1'b1; step(4);

    cur_req = "R1";                       // reset mid-run
    halt_req = 1'b1; step(1); halt_req = 1'b0; rst_n = 1'b0; step(2);
    rst_n = 1'b1; step(2);

    finish_run();
  end
endmodule